// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is a clock-domain master for an external 12-bit successive-approximation converter that is reached over a four-wire serial link. A user asserts a one-cycle request together with a channel number, a single-ended or differential choice and two framing options. The block then drops chip select, produces the serial clock by dividing the system clock, and sends a start bit followed by the mode flag and the channel bits. It skips the converter's sample window and checks the null bit. It then collects the twelve result bits, most significant first, and returns the code with a one-cycle done strobe and an error flag.

Two framing options are chosen per request. With byte alignment, zeros are sent ahead of the start bit so that the whole exchange takes exactly 24 serial clocks, which suits ports that move whole bytes. With mirrored readback, chip select stays low after the last data bit while the converter repeats the word least significant bit first, without repeating the shared bit. The block then takes its result from that repeated copy and flags an error if the two copies disagree.

The controller is one state machine. It has five states: IDLE (select high, waiting), SETUP (select low, before the first clock edge), SCK_HI and SCK_LO (the two halves of each serial clock period) and GAP (select high for the minimum time between frames). The transitions are as follows. IDLE goes to SETUP on a request. SETUP goes to SCK_HI when its timer expires, and that step is the first rising edge. SCK_HI goes to SCK_LO when the half-period expires, and that step is a falling edge. SCK_LO goes back to SCK_HI for the next rising edge, or goes to GAP once the last rising edge of the frame is done. GAP returns to IDLE when the hold-off expires.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, chip select is high, the serial clock is low and done is low. The serial clock never goes high while chip select is high.
- R2: The first serial bit that is 1 after chip select falls is the start bit. Without byte alignment it is sent on the first rising edge. It is followed by the mode flag (1 = single-ended, 0 = differential) and then the three channel bits, most significant first.
- R3: The serial clock idles low. The data-out line changes only while the serial clock is low and stays stable throughout every high phase.
- R4: Each half of the serial clock lasts HALF_DIV system cycles (63 by default, about 1.98 MHz at 250 MHz). The resulting rate must lie between 10 kHz and 2 MHz.
- R5: The first rising edge comes at least 100 ns after chip select falls. Chip select stays high for at least 500 ns between two frames.
- R6: The bit at position 7 after the start bit is the null bit. Positions 8 to 19 carry the result, most significant bit first, as a straight binary code from 0 to 4095.
- R7: Done is high for exactly one system cycle, at the last rising edge of the frame. A plain frame has 19 rising edges.
- R8: If the bit captured at the null position is 1, the error flag is high when done is high. Otherwise the error flag is low in a plain frame.
- R9: With byte alignment, 5 zero bits come before the start bit, so the start bit is on rising edge 6 and the frame has 24 rising edges.
- R10: With mirrored readback, the frame runs 11 more rising edges (30 plain, 35 aligned). The result is built from the mirrored copy: positions 20 to 30 carry bits 1 to 11, and bit 0 is shared. The error flag is raised when the two copies differ.
- R11: A request made while a frame or its hold-off is in progress is ignored. It neither starts a frame nor changes the one in progress.
- R12: The result and the error flag keep their values from done until the next accepted request, whatever the request-side inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start a conversion (accepted in IDLE only) |
| chan | input | CH_W | Channel number |
| diff | input | 1 | 1 selects a differential pair, 0 a single-ended input |
| align8 | input | 1 | Pad the frame to 24 serial clocks |
| lsb_tail | input | 1 | Read the mirrored tail and cross-check it |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the converter |
| done | output | 1 | One-cycle strobe when the result is ready |
| result | output | DATA_W | Conversion code |
| err | output | 1 | Null-bit or mirror mismatch error, valid with done |

## Verification
The situations hardest to reach from the ports are a null bit that reads 1 and a mirrored tail that disagrees with the first copy, because a well-behaved converter produces neither. The bench drives the link from a behavioural converter model that decodes the start, mode and channel bits exactly as the real device does. On demand the model drives a 1 in the null slot or inverts one bit of the mirrored tail. A second request pulsed in the middle of a long frame checks that the busy controller drops it.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SCK_HI,
        ST_SCK_LO,
        ST_GAP
    } rd_state_e;

    typedef struct packed {
        logic align;
        logic tail;
    } rd_mode_t;

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= len;
        else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
    end

    assign expire = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_txseq.sv
module adc_rd_txseq #(
    parameter int unsigned CH_W = 3,
    parameter int unsigned LEAD = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            shift,
    input  logic            diff,
    input  logic            align,
    input  logic [CH_W-1:0] chan,
    output logic            mosi
);
    localparam int unsigned CMD_W = CH_W + 2;
    localparam int unsigned SH_W  = CMD_W + LEAD;

    logic [CMD_W-1:0] cmd;
    logic [SH_W-1:0]  sh_q;

    assign cmd = {1'b1, ~diff, chan};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sh_q <= '0;
        else if (load)  sh_q <= align ? SH_W'(cmd) : (SH_W'(cmd) << LEAD);
        else if (shift) sh_q <= sh_q << 1;
    end

    assign mosi = sh_q[SH_W-1];

    // R2
    start_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !align) |=> mosi);
endmodule

// File: rtl/adc_rd_rxcap.sv
module adc_rd_rxcap #(
    parameter int unsigned DATA_W   = 12,
    parameter int unsigned K_W      = 6,
    parameter int unsigned NULL_POS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic [K_W-1:0]    rel,
    input  logic              miso,
    input  logic              tail_mode,
    output logic [DATA_W-1:0] result,
    output logic              err
);
    logic [DATA_W-1:0] msb_sr;
    logic [DATA_W-2:0] tail_sr;
    logic              null_bad;
    logic              in_data, in_tail;

    assign in_data = (rel > K_W'(NULL_POS)) && (rel <= K_W'(NULL_POS + DATA_W));
    assign in_tail = (rel > K_W'(NULL_POS + DATA_W)) &&
                     (rel <= K_W'(NULL_POS + 2*DATA_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msb_sr   <= '0;
            tail_sr  <= '0;
            null_bad <= 1'b0;
        end else if (clear) begin
            msb_sr   <= '0;
            tail_sr  <= '0;
            null_bad <= 1'b0;
        end else if (capture) begin
            if (rel == K_W'(NULL_POS)) null_bad <= miso;
            else if (in_data)          msb_sr   <= {msb_sr[DATA_W-2:0], miso};
            else if (in_tail)          tail_sr  <= {miso, tail_sr[DATA_W-2:1]};
        end
    end

    assign result = tail_mode ? {tail_sr, msb_sr[0]} : msb_sr;
    assign err    = null_bad | (tail_mode & (tail_sr != msb_sr[DATA_W-1:1]));

    // R8
    null_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !clear && rel == K_W'(NULL_POS) && miso) |=> err);
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl import adc_rd_pkg::*; #(
    parameter int unsigned SYS_HZ   = 250_000_000,
    parameter int unsigned HALF_DIV = 63,
    parameter int unsigned DATA_W   = 12,
    parameter int unsigned CH_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [CH_W-1:0]   chan,
    input  logic              diff,
    input  logic              align8,
    input  logic              lsb_tail,
    input  logic              miso,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic              err
);
    localparam int unsigned CMD_W      = CH_W + 2;
    localparam int unsigned NULL_POS   = CMD_W + 2;
    localparam int unsigned BODY       = NULL_POS + DATA_W;
    localparam int unsigned BYTE_CLKS  = ((BODY + 7) / 8) * 8;
    localparam int unsigned ALIGN_LEAD = BYTE_CLKS - BODY;
    localparam int unsigned MAX_K      = ALIGN_LEAD + BODY + DATA_W - 1;
    localparam int unsigned K_W        = $clog2(MAX_K + 1);
    localparam int unsigned SU_MIN     = (SYS_HZ + 9_999_999) / 10_000_000;
    localparam int unsigned SU_CYC     = (HALF_DIV > SU_MIN) ? HALF_DIV : SU_MIN;
    localparam int unsigned CSH_CYC    = (SYS_HZ + 1_999_999) / 2_000_000;
    localparam int unsigned TMR_MAX0   = (SU_CYC > CSH_CYC) ? SU_CYC : CSH_CYC;
    localparam int unsigned TMR_MAX    = (TMR_MAX0 > HALF_DIV) ? TMR_MAX0 : HALF_DIV;
    localparam int unsigned TMR_W      = $clog2(TMR_MAX + 1);
    localparam int unsigned MIN_HALF   = (SYS_HZ + 3_999_999) / 4_000_000;
    localparam int unsigned MAX_HALF   = SYS_HZ / 20_000;

    rd_state_e        st_q, st_d;
    rd_mode_t         mode_q;
    logic [K_W-1:0]   k_q, k_nx, lead, last_k;
    logic             tmr_load, tmr_exp;
    logic [TMR_W-1:0] tmr_len;
    logic             cap, fall, frame_load;
    logic             cs_n_q, sclk_q, done_q;

    assign k_nx   = k_q + K_W'(1);
    assign lead   = mode_q.align ? K_W'(ALIGN_LEAD) : '0;
    assign last_k = lead + K_W'(BODY) + (mode_q.tail ? K_W'(DATA_W - 1) : '0);

    adc_rd_timer #(.W(TMR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .len    (tmr_len),
        .expire (tmr_exp)
    );

    adc_rd_txseq #(.CH_W(CH_W), .LEAD(ALIGN_LEAD)) u_txseq (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_load),
        .shift (fall),
        .diff  (diff),
        .align (align8),
        .chan  (chan),
        .mosi  (mosi)
    );

    adc_rd_rxcap #(.DATA_W(DATA_W), .K_W(K_W), .NULL_POS(NULL_POS)) u_rxcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (frame_load),
        .capture   (cap && (k_nx > lead)),
        .rel       (k_nx - lead),
        .miso      (miso),
        .tail_mode (mode_q.tail),
        .result    (result),
        .err       (err)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state and strobes
    always_comb begin
        st_d       = st_q;
        tmr_load   = 1'b0;
        tmr_len    = '0;
        cap        = 1'b0;
        fall       = 1'b0;
        frame_load = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req) begin
                    st_d       = ST_SETUP;
                    tmr_load   = 1'b1;
                    tmr_len    = TMR_W'(SU_CYC - 1);
                    frame_load = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    st_d     = ST_SCK_HI;
                    tmr_load = 1'b1;
                    tmr_len  = TMR_W'(HALF_DIV - 1);
                    cap      = 1'b1;
                end
            end
            ST_SCK_HI: begin
                if (tmr_exp) begin
                    st_d     = ST_SCK_LO;
                    tmr_load = 1'b1;
                    tmr_len  = TMR_W'(HALF_DIV - 1);
                    fall     = 1'b1;
                end
            end
            ST_SCK_LO: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (k_q == last_k) begin
                        st_d    = ST_GAP;
                        tmr_len = TMR_W'(CSH_CYC - 1);
                    end else begin
                        st_d    = ST_SCK_HI;
                        tmr_len = TMR_W'(HALF_DIV - 1);
                        cap     = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_exp) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            k_q    <= '0;
        end else if (frame_load) begin
            mode_q <= '{align: align8, tail: lsb_tail};
            k_q    <= '0;
        end else if (cap) begin
            k_q    <= k_nx;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            cs_n_q <= (st_d == ST_IDLE) || (st_d == ST_GAP);
            sclk_q <= (st_d == ST_SCK_HI);
            done_q <= cap && (k_nx == last_k);
        end
    end

    assign cs_n = cs_n_q;
    assign sclk = sclk_q;
    assign done = done_q;

    // checker counters for clock-rate and select-gap properties
    logic [31:0] hi_len, cs_hi_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len    <= '0;
            cs_hi_len <= CSH_CYC;
        end else begin
            hi_len    <= sclk_q ? hi_len + 32'd1 : '0;
            if (!cs_n_q)                 cs_hi_len <= '0;
            else if (cs_hi_len < CSH_CYC) cs_hi_len <= cs_hi_len + 32'd1;
        end
    end

    // R1
    idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_q |-> !sclk_q);

    // R3
    mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && $past(sclk_q)) |-> $stable(mosi));

    // R4
    half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_q) |-> (hi_len >= MIN_HALF && hi_len <= MAX_HALF));

    // R5
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_q) |-> (cs_hi_len >= CSH_CYC));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R7
    done_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (k_q == last_k && sclk_q));

    // R9
    lead_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q && mode_q.align && k_q <= K_W'(ALIGN_LEAD)) |-> !mosi);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> $stable(mode_q));

    // R12
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !req) |=> ($stable(result) && $stable(err)));
endmodule

// File: tb/adc_rd_ctrl_bench.sv
`timescale 1ns/1ps
module adc_rd_ctrl_bench;
    localparam int HALF = 63;
    localparam int SU   = 63;
    localparam int GAP  = 125;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  chan = '0;
    logic        diff = 1'b0, align8 = 1'b0, lsb_tail = 1'b0;
    logic        miso, cs_n, sclk, mosi, done, err;
    logic [11:0] result;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    adc_rd_ctrl u_adc_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .chan(chan), .diff(diff),
        .align8(align8), .lsb_tail(lsb_tail), .miso(miso), .cs_n(cs_n),
        .sclk(sclk), .mosi(mosi), .done(done), .result(result), .err(err)
    );

    // behavioural converter
    int          dev_rises = 0, dev_pos = 0, dev_start = 0, p = 0;
    logic [3:0]  dev_cmd = '0;
    logic [11:0] dev_code = '0;
    logic        dev_null = 1'b0, dev_flip = 1'b0, dev_out = 1'b1;

    assign miso = cs_n ? 1'b1 : dev_out;

    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            dev_rises = 0;
            dev_pos   = 0;
        end else begin
            dev_rises++;
            if (dev_pos == 0) begin
                if (mosi) begin
                    dev_pos   = 1;
                    dev_start = dev_rises;
                end
            end else begin
                dev_pos++;
                if (dev_pos >= 2 && dev_pos <= 5) dev_cmd[5-dev_pos] = mosi;
            end
        end
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            p = dev_pos + 1;
            if (dev_pos == 0)              dev_out = 1'b1;
            else if (p == 7)               dev_out = dev_null;
            else if (p >= 8 && p <= 19)    dev_out = dev_code[19-p];
            else if (p >= 20 && p <= 30)   dev_out = dev_code[p-19] ^ (dev_flip && p == 25);
            else                           dev_out = 1'b0;
        end
    end

    // port monitor, sampled away from the active edge
    int cyc = 0, t_csf = 0, t_csr = 0, t_rise = 0, t_sfall = 0;
    int setup_meas = 0, hi_meas = 0, lo_meas = 0, gap_min = 1 << 30;
    int done_cnt = 0, cs_falls = 0, mosi_bad = 0;
    bit first_pend = 0, seen_csr = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (prev_cs && !cs_n) begin
            t_csf = cyc; first_pend = 1; cs_falls++;
            if (seen_csr && (cyc - t_csr) < gap_min) gap_min = cyc - t_csr;
        end
        if (!prev_cs && cs_n) begin t_csr = cyc; seen_csr = 1; end
        if (!prev_sclk && sclk) begin
            if (first_pend) begin setup_meas = cyc - t_csf; first_pend = 0; end
            else lo_meas = cyc - t_sfall;
            t_rise = cyc;
        end
        if (prev_sclk && !sclk) begin hi_meas = cyc - t_rise; t_sfall = cyc; end
        if (sclk && prev_sclk && mosi != prev_mosi) mosi_bad++;
        if (done) done_cnt++;
        prev_cs = cs_n; prev_sclk = sclk; prev_mosi = mosi;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic pulse_req(input logic [2:0] ch, input logic df, input logic al, input logic tl);
        @(negedge clk);
        chan = ch; diff = df; align8 = al; lsb_tail = tl; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        bit got = 0;
        for (int i = 0; i < 20000 && !got; i++) begin
            @(negedge clk);
            if (done) got = 1;
        end
        chk(got, {tag, " done seen"}, got, 1);
    endtask

    task automatic wait_idle();
        while (!cs_n) @(negedge clk);
        repeat (GAP + 10) @(negedge clk);
    endtask

    task automatic frame(input logic [2:0] ch, input logic df, input logic al, input logic tl,
                         input logic [11:0] code, input logic nv, input logic fl, input string tag);
        dev_code = code; dev_null = nv; dev_flip = fl; done_cnt = 0;
        pulse_req(ch, df, al, tl);
        wait_done(tag);
    endtask

    task automatic t_reset();
        chk(cs_n == 1'b1, "R1 cs_n after reset", cs_n, 1);
        chk(sclk == 1'b0, "R1 sclk after reset", sclk, 0);
        chk(done == 1'b0, "R1 done after reset", done, 0);
    endtask

    task automatic t_single();
        frame(3'd5, 1'b0, 1'b0, 1'b0, 12'hA5C, 1'b0, 1'b0, "R6 single");
        chk(result == 12'hA5C, "R6 single-ended result", result, 12'hA5C);
        chk(err == 1'b0, "R8 no error on clean frame", err, 0);
        chk(dev_start == 1, "R2 start on first rising edge", dev_start, 1);
        chk(dev_cmd == 4'b1101, "R2 mode and channel bits", dev_cmd, 4'b1101);
        chk(dev_rises == 19, "R7 plain frame length", dev_rises, 19);
        chk(setup_meas == SU && setup_meas * 4 >= 100, "R5 select-to-first-edge", setup_meas, SU);
        chk(hi_meas == HALF, "R4 high half-period", hi_meas, HALF);
        chk(lo_meas == HALF, "R4 low half-period", lo_meas, HALF);
        chk(hi_meas * 8 >= 500 && hi_meas * 8 <= 100_000, "R4 serial clock rate window ns", hi_meas * 8, 504);
        @(negedge clk);
        chk(done == 1'b0 && done_cnt == 1, "R7 done lasts one cycle", done_cnt, 1);
        wait_idle();
    endtask

    task automatic t_diff_extremes();
        frame(3'd2, 1'b1, 1'b0, 1'b0, 12'h000, 1'b0, 1'b0, "R6 zero");
        chk(result == 12'h000, "R6 minimum code", result, 0);
        chk(dev_cmd == 4'b0010, "R2 differential flag", dev_cmd, 4'b0010);
        wait_idle();
        frame(3'd7, 1'b1, 1'b0, 1'b0, 12'hFFF, 1'b0, 1'b0, "R6 full");
        chk(result == 12'hFFF, "R6 maximum code", result, 12'hFFF);
        chk(dev_cmd == 4'b0111, "R2 channel 7 bits", dev_cmd, 4'b0111);
        wait_idle();
    endtask

    task automatic t_null_err();
        frame(3'd1, 1'b0, 1'b0, 1'b0, 12'h123, 1'b1, 1'b0, "R8 null");
        chk(err == 1'b1, "R8 null bit high flags error", err, 1);
        chk(result == 12'h123, "R8 data still captured", result, 12'h123);
        wait_idle();
    endtask

    task automatic t_aligned();
        frame(3'd3, 1'b0, 1'b1, 1'b0, 12'h3C1, 1'b0, 1'b0, "R9 aligned");
        chk(dev_start == 6, "R9 start after five zeros", dev_start, 6);
        chk(dev_rises == 24, "R9 aligned frame length", dev_rises, 24);
        chk(result == 12'h3C1, "R9 aligned result", result, 12'h3C1);
        chk(dev_cmd == 4'b1011, "R9 aligned command bits", dev_cmd, 4'b1011);
        wait_idle();
    endtask

    task automatic t_tail();
        frame(3'd4, 1'b0, 1'b0, 1'b1, 12'h6B2, 1'b0, 1'b0, "R10 tail");
        chk(dev_rises == 30, "R10 tail frame length", dev_rises, 30);
        chk(result == 12'h6B2 && err == 1'b0, "R10 tail result", result, 12'h6B2);
        wait_idle();
        frame(3'd6, 1'b1, 1'b1, 1'b1, 12'h801, 1'b0, 1'b0, "R10 aligned tail");
        chk(dev_rises == 35, "R10 aligned tail frame length", dev_rises, 35);
        chk(result == 12'h801 && err == 1'b0, "R10 aligned tail result", result, 12'h801);
        wait_idle();
        frame(3'd0, 1'b0, 1'b0, 1'b1, 12'h555, 1'b0, 1'b1, "R10 mismatch");
        chk(err == 1'b1, "R10 tail mismatch flags error", err, 1);
        chk(result == (12'h555 ^ 12'h040), "R10 result from mirrored copy", result, 12'h515);
        wait_idle();
    endtask

    task automatic t_busy();
        int falls0;
        dev_code = 12'h2E7; dev_null = 0; dev_flip = 0; done_cnt = 0;
        falls0 = cs_falls;
        pulse_req(3'd6, 1'b0, 1'b0, 1'b0);
        repeat (600) @(negedge clk);
        pulse_req(3'd1, 1'b1, 1'b1, 1'b1);
        wait_done("R11 busy");
        chk(dev_cmd == 4'b1110, "R11 frame keeps first command", dev_cmd, 4'b1110);
        chk(dev_rises == 19, "R11 frame keeps first framing", dev_rises, 19);
        chk(result == 12'h2E7, "R11 result of first request", result, 12'h2E7);
        repeat (3000) @(negedge clk);
        chk(cs_falls - falls0 == 1, "R11 late request started nothing", cs_falls - falls0, 1);
        chk(done_cnt == 1, "R11 single done", done_cnt, 1);
    endtask

    task automatic t_hold();
        chan = 3'd2; diff = 1'b1; align8 = 1'b1; lsb_tail = 1'b1;
        repeat (500) @(negedge clk);
        chk(result == 12'h2E7, "R12 result held", result, 12'h2E7);
        chk(err == 1'b0, "R12 error held", err, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (200) @(negedge clk);
        t_reset();
        t_single();
        t_diff_extremes();
        t_null_err();
        t_aligned();
        t_tail();
        t_busy();
        t_hold();
        chk(mosi_bad == 0, "R3 mosi stable while clock high", mosi_bad, 0);
        chk(gap_min >= GAP, "R5 select high between frames", gap_min, GAP);
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end
endmodule